// File: doc/BRIEF.md
# Clock output power-down sequencer

This block sequences the stop and restart of a clock generator's outputs around a power-down request. A single active-low input has two roles. After reset it acts as a power-good indication. Once it has been seen high, the same pin becomes an active-low power-down request for as long as the block runs. The request is asynchronous, so it passes through a synchronizer before it affects anything. The block accepts it only after two consecutive rising edges of a reference clock have seen it active.

All clock sources, the reference clock and the PLL lock input are sampled as data on one fast system clock. When a power-down is accepted, each single-ended output stops on its own falling edge. Each differential pair stops when its complement falls. A per-pair drive-mode bit, captured at acceptance, chooses the parked state of a pair: driven true-high/complement-low, or tri-stated with both legs low. The oscillator and synthesizer enables are removed only after every output is parked.

On wake-up the enables return first: the oscillator enable, then the synthesizer enable one cycle later. Tri-stated pairs are driven again in the high/low park state. Outputs are released only after lock, each in its own safe phase. A lock-timeout flag is raised if lock takes too long.

Top module: `clkout_pwrseq`

## Requirements
- R1: After reset, and while the shared pin stays low, all single-ended outputs are 0 and every pair has oe=0, true=0, complement=0. osc_en, syn_en and lock_tmo are 0 whatever the lock input does.
- R2: The shared pin goes through a two-stage synchronizer. The first time it is seen high, osc_en rises within 4 cycles. From then on, a low level on the pin is a power-down request.
- R3: A power-down request is accepted only when two consecutive rising edges of the reference input both see it. A request lasting less than one reference period leaves every output running.
- R4: A single-ended output follows its source while running. Every high pulse it drives lasts the full source high time, including the last pulse before a stop.
- R5: After acceptance, each pair stops on a rising edge of its source, which is the falling edge of the complement. It stops within 4 periods of its source, and the complement's last pulse is full length.
- R6: A stopped pair whose captured mode bit is 0 drives true=1, complement=0, oe=1. True and complement are never both 1.
- R7: A stopped pair whose captured mode bit is 1 drives true=0, complement=0, oe=0. Whenever oe is 0, both legs are 0.
- R8: osc_en and syn_en fall only once every output is parked. While osc_en is 0, all single-ended outputs are 0.
- R9: When the request is removed, osc_en returns, and syn_en follows one cycle later. Before lock, every pair drives true=1, complement=0, oe=1, and every single-ended output stays 0.
- R10: Outputs are released only after lock is seen with syn_en high. All outputs are running within two periods of the slowest source.
- R11: Each single-ended output is released during a low phase of its source, and each pair during a high phase. The first pulse after release is full length.
- R12: lock_tmo rises after LOCK_TMO cycles of waiting for lock. It is asserted only while waiting and clears when lock is seen.
- R13: The mode bits are captured when a power-down is accepted. Changing them afterwards has no effect on parked pairs until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_pdn | input | 1 | Power-good at first, then active-low power-down request |
| ref_clk | input | 1 | Reference clock (sampled) used to qualify the request |
| pll_lock | input | 1 | Synthesizer lock indication |
| se_src | input | N_SE | Single-ended clock sources |
| df_src | input | N_DIFF | Differential sources (true phase) |
| drv_mode | input | N_DIFF | Per-pair park mode: 0 drive high/low, 1 tri-state |
| se_out | output | N_SE | Gated single-ended clocks |
| df_t | output | N_DIFF | Gated true legs |
| df_c | output | N_DIFF | Gated complement legs |
| df_oe | output | N_DIFF | Per-pair output enables |
| osc_en | output | 1 | Oscillator enable |
| syn_en | output | 1 | Synthesizer enable |
| lock_tmo | output | 1 | Lock wait exceeded LOCK_TMO cycles |

## Verification
The hardest case to reach is a stop whose request lands at an arbitrary phase of every source at once. Only that shows whether some output ends a pulse early or a tri-stated true leg produces a runt. The bench runs its sources at different half-periods and waits a random number of cycles before each request, so the phases of acceptance differ from iteration to iteration. A pulse-width monitor measures every completed high pulse against the source's half-period. Directed iterations cover all-drive and all-tri-state modes, and random iterations mix the two. The short request pulse and the wait for a lock that never comes are driven directly.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    ST_PGOOD   = 3'd0,
    ST_LOCKW   = 3'd1,
    ST_RELEASE = 3'd2,
    ST_RUN     = 3'd3,
    ST_STOP    = 3'd4,
    ST_OFF     = 3'd5
  } cps_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/cps_se_gate.sv
module cps_se_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic go,
  output logic out,
  output logic running
);
  logic run_q, run_n;
  logic out_q, out_n;

  // state changes only while the source is low: no shortened pulse
  always_comb begin
    if (run_q) run_n = go | src;
    else       run_n = go & ~src;
    out_n = run_n & src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_n;
      out_q <= out_n;
    end
  end

  assign out     = out_q;
  assign running = run_q;
endmodule

// File: rtl/cps_diff_gate.sv
module cps_diff_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic go,
  input  logic hold,
  input  logic mode,
  output logic t,
  output logic c,
  output logic oe,
  output logic running
);
  logic src_p;
  logic rise;
  logic run_q, run_n;
  logic t_q, c_q, oe_q;
  logic t_n, c_n, oe_n;

  always_comb begin
    rise = src & ~src_p;
    // stop only when the complement is about to fall; start in the high phase
    if (run_q) run_n = ~(~go & rise);
    else       run_n = go & src;
    if (run_n) begin
      t_n  = src;
      c_n  = ~src;
      oe_n = 1'b1;
    end else if (hold || !mode) begin
      t_n  = 1'b1;
      c_n  = 1'b0;
      oe_n = 1'b1;
    end else begin
      t_n  = 1'b0;
      c_n  = 1'b0;
      oe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_p <= 1'b0;
      run_q <= 1'b0;
      t_q   <= 1'b0;
      c_q   <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      src_p <= src;
      run_q <= run_n;
      t_q   <= t_n;
      c_q   <= c_n;
      oe_q  <= oe_n;
    end
  end

  assign t       = t_q;
  assign c       = c_q;
  assign oe      = oe_q;
  assign running = run_q;
endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int N_DIFF   = 3,
  parameter int LOCK_TMO = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic              ref_clk,
  input  logic              pll_lock,
  input  logic              all_run,
  input  logic              all_stop,
  input  logic [N_DIFF-1:0] drv_mode,
  output logic              gate_go,
  output logic              drv_hold,
  output logic [N_DIFF-1:0] mode_q,
  output logic              osc_en,
  output logic              syn_en,
  output logic              lock_tmo,
  output cps_state_e        st
);
  localparam int TW = $clog2(LOCK_TMO + 1);

  cps_state_e        st_q, st_n;
  logic              ref_p;
  logic              seen_q, seen_n;
  logic              ref_rise, accept;
  logic [N_DIFF-1:0] mode_r;
  logic              mode_cap;
  logic              osc_q, syn_q, en_n;
  logic [TW-1:0]     tmo_q, tmo_n;

  always_comb begin
    ref_rise = ref_clk & ~ref_p;
    seen_n   = seen_q;
    if (st_q != ST_RUN)  seen_n = 1'b0;
    else if (ref_rise)   seen_n = ~pin_s;
    accept   = (st_q == ST_RUN) & ref_rise & ~pin_s & seen_q;
    mode_cap = accept;

    st_n = st_q;
    case (st_q)
      ST_PGOOD:   if (pin_s) st_n = ST_LOCKW;
      ST_LOCKW:   if (syn_q && pll_lock) st_n = ST_RELEASE;
      ST_RELEASE: if (all_run) st_n = ST_RUN;
      ST_RUN:     if (accept) st_n = ST_STOP;
      ST_STOP:    if (all_stop) st_n = ST_OFF;
      ST_OFF:     if (pin_s) st_n = ST_LOCKW;
      default:    st_n = ST_PGOOD;
    endcase

    en_n = (st_n == ST_LOCKW) || (st_n == ST_RELEASE) ||
           (st_n == ST_RUN)   || (st_n == ST_STOP);

    if (st_q == ST_LOCKW && st_n == ST_LOCKW) begin
      if (tmo_q == TW'(LOCK_TMO)) tmo_n = tmo_q;
      else                        tmo_n = tmo_q + TW'(1);
    end else begin
      tmo_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PGOOD;
      ref_p  <= 1'b0;
      seen_q <= 1'b0;
      osc_q  <= 1'b0;
      syn_q  <= 1'b0;
      tmo_q  <= '0;
    end else begin
      st_q   <= st_n;
      ref_p  <= ref_clk;
      seen_q <= seen_n;
      osc_q  <= en_n;
      syn_q  <= en_n & osc_q;
      tmo_q  <= tmo_n;
    end
  end

  // mode capture register with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_r <= '1;
    else if (mode_cap) mode_r <= drv_mode;
  end

  assign gate_go  = (st_q == ST_RELEASE) || (st_q == ST_RUN);
  assign drv_hold = (st_q == ST_LOCKW) || (st_q == ST_RELEASE);
  assign mode_q   = mode_r;
  assign osc_en   = osc_q;
  assign syn_en   = syn_q;
  assign lock_tmo = (tmo_q == TW'(LOCK_TMO));
  assign st       = st_q;
endmodule

// File: rtl/clkout_pwrseq.sv
module clkout_pwrseq
  import cps_pkg::*;
#(
  parameter int N_SE        = 3,
  parameter int N_DIFF      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_TMO    = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_pdn,
  input  logic              ref_clk,
  input  logic              pll_lock,
  input  logic [N_SE-1:0]   se_src,
  input  logic [N_DIFF-1:0] df_src,
  input  logic [N_DIFF-1:0] drv_mode,
  output logic [N_SE-1:0]   se_out,
  output logic [N_DIFF-1:0] df_t,
  output logic [N_DIFF-1:0] df_c,
  output logic [N_DIFF-1:0] df_oe,
  output logic              osc_en,
  output logic              syn_en,
  output logic              lock_tmo
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              pin_s;
  logic              gate_go, drv_hold;
  logic [N_DIFF-1:0] mode_w;
  logic [N_SE-1:0]   se_run;
  logic [N_DIFF-1:0] df_run;
  logic              all_run, all_stop;
  cps_state_e        st_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  cps_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_s), .d(pg_pdn), .q(pin_s)
  );

  assign all_run  = (&se_run) & (&df_run);
  assign all_stop = ~(|se_run) & ~(|df_run);

  cps_ctrl #(.N_DIFF(N_DIFF), .LOCK_TMO(LOCK_TMO)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .pin_s(pin_s), .ref_clk(ref_clk),
    .pll_lock(pll_lock), .all_run(all_run), .all_stop(all_stop),
    .drv_mode(drv_mode), .gate_go(gate_go), .drv_hold(drv_hold),
    .mode_q(mode_w), .osc_en(osc_en), .syn_en(syn_en),
    .lock_tmo(lock_tmo), .st(st_w)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    cps_se_gate u_gate (
      .clk(clk), .rst_n(rst_s), .src(se_src[i]), .go(gate_go),
      .out(se_out[i]), .running(se_run[i])
    );
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_df
    cps_diff_gate u_gate (
      .clk(clk), .rst_n(rst_s), .src(df_src[j]), .go(gate_go),
      .hold(drv_hold), .mode(mode_w[j]),
      .t(df_t[j]), .c(df_c[j]), .oe(df_oe[j]), .running(df_run[j])
    );
  end
endmodule

// File: rtl/cps_chk.sv
module cps_chk
  import cps_pkg::*;
#(
  parameter int N_SE       = 3,
  parameter int N_DIFF     = 3,
  parameter int STOP_LIMIT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SE-1:0]   se_out,
  input logic [N_DIFF-1:0] df_t,
  input logic [N_DIFF-1:0] df_c,
  input logic [N_DIFF-1:0] df_oe,
  input logic              osc_en,
  input logic              syn_en,
  input logic              lock_tmo,
  input cps_state_e        st,
  input logic [N_DIFF-1:0] mode_q
);
  int unsigned stop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stop_cnt <= 0;
    else if (st == ST_STOP)  stop_cnt <= stop_cnt + 1;
    else                     stop_cnt <= 0;
  end

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (se_out == '0));

  p_syn_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syn_en) |-> $past(osc_en));

  p_tri_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~df_oe) & (df_t | df_c)) == '0);

  p_pair_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (df_t & df_c) == '0);

  p_stop_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cnt <= STOP_LIMIT);

  p_tmo_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tmo |-> (st == ST_LOCKW));

  p_hold_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCKW && $past(st) == ST_LOCKW) |-> (&df_oe));

  p_mode_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && $past(st) == ST_OFF) |-> $stable(mode_q));
endmodule

bind clkout_pwrseq cps_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
  .clk(clk), .rst_n(rst_s), .se_out(se_out), .df_t(df_t), .df_c(df_c),
  .df_oe(df_oe), .osc_en(osc_en), .syn_en(syn_en), .lock_tmo(lock_tmo),
  .st(st_w), .mode_q(mode_w)
);

// File: tb/sim_clkout_pwrseq.sv
module sim_clkout_pwrseq;
  localparam int CLK_P    = 10;
  localparam int N_SE     = 3;
  localparam int N_DIFF   = 3;
  localparam int LOCK_TMO = 40;
  localparam int REF_H    = 3;
  localparam int MAX_P    = 10;
  localparam int WD       = 150000;

  logic clk = 1'b0;
  logic rst_n, pg_pdn, ref_clk, pll_lock;
  logic [N_SE-1:0]   se_src;
  logic [N_DIFF-1:0] df_src, drv_mode;
  logic [N_SE-1:0]   se_out;
  logic [N_DIFF-1:0] df_t, df_c, df_oe;
  logic osc_en, syn_en, lock_tmo;
  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  clkout_pwrseq #(.N_SE(N_SE), .N_DIFF(N_DIFF), .LOCK_TMO(LOCK_TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pg_pdn(pg_pdn), .ref_clk(ref_clk),
    .pll_lock(pll_lock), .se_src(se_src), .df_src(df_src),
    .drv_mode(drv_mode), .se_out(se_out), .df_t(df_t), .df_c(df_c),
    .df_oe(df_oe), .osc_en(osc_en), .syn_en(syn_en), .lock_tmo(lock_tmo)
  );

  function automatic int se_half(int i); return 3 + i; endfunction
  function automatic int df_half(int j); return 2 + j; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic at_sample(); @(posedge clk); #2; endtask
  task automatic wait_cyc(int n); repeat (n) at_sample(); endtask

  // source generators: drive on falling edges
  initial begin
    int sc[N_SE];
    int dc[N_DIFF];
    int rc;
    se_src = '0; df_src = '0; ref_clk = 1'b0; rc = 0;
    for (int i = 0; i < N_SE; i++) sc[i] = 0;
    for (int j = 0; j < N_DIFF; j++) dc[j] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < N_SE; i++) begin
        sc[i]++;
        if (sc[i] == se_half(i)) begin se_src[i] = ~se_src[i]; sc[i] = 0; end
      end
      for (int j = 0; j < N_DIFF; j++) begin
        dc[j]++;
        if (dc[j] == df_half(j)) begin df_src[j] = ~df_src[j]; dc[j] = 0; end
      end
      rc++;
      if (rc == REF_H) begin ref_clk = ~ref_clk; rc = 0; end
    end
  end

  // pulse-width monitor for R4, R5 and R11
  initial begin
    int sl[N_SE];
    int cl[N_DIFF];
    logic [N_SE-1:0]   sp;
    logic [N_DIFF-1:0] cp;
    sp = '0; cp = '0;
    for (int i = 0; i < N_SE; i++) sl[i] = 0;
    for (int j = 0; j < N_DIFF; j++) cl[j] = 0;
    forever begin
      at_sample();
      if (mon_en) begin
        for (int i = 0; i < N_SE; i++) begin
          if (se_out[i]) sl[i]++;
          else if (sp[i]) begin
            chk(sl[i] == se_half(i), "R4 R11", "se pulse width", sl[i], se_half(i));
            sl[i] = 0;
          end
        end
        for (int j = 0; j < N_DIFF; j++) begin
          if (df_c[j]) cl[j]++;
          else if (cp[j]) begin
            chk(cl[j] == df_half(j), "R5 R11", "complement pulse width", cl[j], df_half(j));
            cl[j] = 0;
          end
        end
        sp = se_out; cp = df_c;
      end
    end
  end

  task automatic check_running(string req);
    bit ok;
    ok = (se_out == se_src) && (df_t == df_src) && (df_c == ~df_src) && (&df_oe);
    chk(ok, req, "outputs follow sources", {se_out, df_t, df_c, df_oe},
        {se_src, df_src, ~df_src, {N_DIFF{1'b1}}});
  endtask

  task automatic check_park(logic [N_DIFF-1:0] m, bit hold, string req);
    logic [N_DIFF-1:0] et, eoe;
    eoe = hold ? {N_DIFF{1'b1}} : ~m;
    et  = eoe;
    chk(df_t == et && df_c == '0 && df_oe == eoe && se_out == '0, req,
        "parked outputs", {df_t, df_c, df_oe, se_out}, {et, {N_DIFF{1'b0}}, eoe, {N_SE{1'b0}}});
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [N_DIFF-1:0] m;
    int el;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pg_pdn = 1'b0; pll_lock = 1'b0; drv_mode = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    mon_en = 1'b1;
    // R1: reset state, lock ignored while pin low
    chk(se_out == '0 && df_oe == '0 && df_t == '0 && df_c == '0, "R1", "reset outputs",
        {se_out, df_oe, df_t, df_c}, 0);
    @(negedge clk); pll_lock = 1'b1;
    wait_cyc(20);
    chk({osc_en, syn_en, lock_tmo} == 3'b000, "R1", "enables with pin low", {osc_en, syn_en, lock_tmo}, 0);
    check_park('1, 1'b0, "R1");
    // R2: power-good
    @(negedge clk); pll_lock = 1'b0; pg_pdn = 1'b1;
    wait_cyc(4);
    chk(osc_en == 1'b1, "R2", "osc_en after power-good", osc_en, 1);
    wait_cyc(2);
    chk(syn_en == 1'b1, "R9", "syn_en after osc_en", syn_en, 1);
    check_park('1, 1'b1, "R9");
    chk(lock_tmo == 1'b0, "R12", "no timeout early", lock_tmo, 0);
    wait_cyc(LOCK_TMO + 5);
    chk(lock_tmo == 1'b1, "R12", "timeout flagged", lock_tmo, 1);
    @(negedge clk); pll_lock = 1'b1;
    wait_cyc(2 * MAX_P + 4);
    chk(lock_tmo == 1'b0, "R12", "timeout cleared", lock_tmo, 0);
    check_running("R10");
    // R3: request shorter than one reference period
    @(negedge clk); pg_pdn = 1'b0;
    @(negedge clk);
    @(negedge clk); pg_pdn = 1'b1;
    wait_cyc(40);
    chk(osc_en == 1'b1, "R3", "short request ignored", osc_en, 1);
    check_running("R3");
    // power-down / wake-up iterations
    for (int k = 0; k < 8; k++) begin
      if (k == 0)      m = '0;
      else if (k == 1) m = '1;
      else             m = N_DIFF'($urandom);
      repeat ($urandom_range(7, 0)) @(negedge clk);
      @(negedge clk); drv_mode = m; pg_pdn = 1'b0;
      el = 0;
      for (int n = 0; n < 200; n++) begin
        at_sample(); el++;
        if (!osc_en) break;
      end
      chk(el >= 2 * REF_H + 2, "R3", "not accepted before two ref edges", el, 2 * REF_H + 2);
      chk(el <= 4 + 4 * REF_H + 4 * 2 * df_half(N_DIFF-1), "R5", "stop latency", el,
          4 + 4 * REF_H + 8 * df_half(N_DIFF-1));
      chk(!osc_en && se_out == '0, "R8", "enables off after parking", {osc_en, se_out}, 0);
      wait_cyc(1);
      check_park(m, 1'b0, (m == '0) ? "R6" : "R7");
      @(negedge clk); drv_mode = ~m; pll_lock = 1'b0;
      wait_cyc(10);
      check_park(m, 1'b0, "R13");
      @(negedge clk); pg_pdn = 1'b1;
      wait_cyc(6);
      chk(osc_en && syn_en, "R9", "enables back", {osc_en, syn_en}, 3);
      check_park(m, 1'b1, "R9");
      @(negedge clk); pll_lock = 1'b1;
      wait_cyc(2 * MAX_P + 4);
      check_running("R10");
    end
    wait_cyc(20);
    summary();
    $finish;
  end
endmodule